// File: doc/BRIEF.md
# Fragment-Serial Wide Adder/Subtractor

This block adds or subtracts two wide operands using a 4-bit arithmetic slice that is reused once per cycle. The operands sit in a small internal register pair that is loaded over a parallel write port with a valid/ready handshake. A start strobe with an add/subtract select then launches a run. Each cycle the slice takes one 4-bit fragment of each operand, lowest fragment first, and the stored carry. It produces one 4-bit partial, which goes straight into its own slot of a result store. Its carry-out goes into a status flag that feeds the next fragment.

Subtraction is done by inverting the second operand and forcing the initial carry to 1. When the last fragment is written, a one-cycle done pulse is raised and busy drops in that same cycle. The final carry and a signed-overflow flag are then valid. A consumer reads the result one fragment at a time through an indexed read port.

Load handshake rules: `ld_ready` is high exactly when no run is active. A word is taken on a rising edge where both `ld_valid` and `ld_ready` are high. While a run is active the port applies back-pressure (`ld_ready` low), and any offered word is dropped, not queued.

Top module: `serial_wide_adder`

## Requirements
- R1: With the select at 0 (add), after a run the result store holds (A + B) mod 2^W and the carry flag holds bit W of A + B.
- R2: With the select at 1 (subtract), the result is (A + ~B + 1) mod 2^W, so A − B mod 2^W. The carry flag is 1 when A ≥ B unsigned (no borrow) and 0 otherwise.
- R3: The overflow flag is 1 exactly when A and the effective second operand (B for add, ~B for subtract) have equal bit W−1 and the result's bit W−1 differs from it; otherwise it is 0.
- R4: A start seen while idle latches the select, and busy is high from the next cycle. The run takes W/4 cycles. Done is high for exactly one cycle, the cycle after the last fragment's edge, and busy is low in that cycle.
- R5: A start seen while busy is ignored: the run in progress, its select and its result are unchanged.
- R6: `ld_ready` equals not-busy. A word offered with `ld_valid` and `ld_ready` high is written to A when `ld_sel` is 0 and to B when `ld_sel` is 1. A word offered while busy is dropped, and the stored operands stay as they were. A word loaded in the same cycle as an accepted start is used by that run.
- R7: Fragment k of the result (bits 4k+3..4k) is written at the k-th edge of the run. From then on it can be read at `rd_data` with `rd_idx` = k, even while the run continues.
- R8: Synchronous reset (`rst_n` low) clears busy, done, both flags, the operands and the result store. After a run, the result and flags hold their values until the next accepted start.
- R9: The carry out of fragment k is stored and added into fragment k+1, so carries and borrows ripple across fragment boundaries (for example 0x0F + 0x01 = 0x10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Operand word offered |
| ld_ready | output | 1 | Operand word can be taken (not busy) |
| ld_sel | input | 1 | Operand target: 0 = A, 1 = B |
| ld_data | input | W | Operand word |
| start | input | 1 | Launch a run when idle |
| op_sub | input | 1 | Operation select: 0 = add, 1 = subtract |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at run completion |
| carry_flag | output | 1 | Carry out of the top fragment |
| ovf_flag | output | 1 | Signed overflow of the run |
| rd_idx | input | log2(W/4) | Result fragment index to read |
| rd_data | output | 4 | Result fragment at `rd_idx` |

## Verification
The done cycle is also an idle cycle, so a new load and a new start can land in the same cycle that the previous run reports completion. The bench provokes this by offering a fresh A operand and raising start at the moment done is observed high. It then judges the following run against an arithmetic expectation built from the new A, and checks that the earlier result was complete when done rose. A second collision, a start or a load offered in mid-run, is judged by comparing the outcome with the expectation from the values held before the run began.

// File: rtl/swa_pkg.sv
package swa_pkg;
  localparam int unsigned FRAG_W = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  typedef struct packed {
    logic [FRAG_W-1:0] sum;
    logic              cout;
    logic              ovf;
  } slice_out_t;
endpackage

// File: rtl/opnd_bank.sv
module opnd_bank #(
  parameter int unsigned OPW    = 32,
  parameter int unsigned FRAG_W = 4,
  localparam int unsigned NFRAG = OPW / FRAG_W,
  localparam int unsigned IDX_W = (NFRAG > 1) ? $clog2(NFRAG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [OPW-1:0]    wdata,
  input  logic [IDX_W-1:0]  idx,
  output logic [FRAG_W-1:0] a_frag,
  output logic [FRAG_W-1:0] b_frag,
  output logic [2*OPW-1:0]  word_o
);
  logic [OPW-1:0] a_q;
  logic [OPW-1:0] b_q;

  for (genvar g = 0; g < NFRAG; g++) begin : g_frag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q[g*FRAG_W +: FRAG_W] <= '0;
        b_q[g*FRAG_W +: FRAG_W] <= '0;
      end else if (we) begin
        if (!sel) a_q[g*FRAG_W +: FRAG_W] <= wdata[g*FRAG_W +: FRAG_W];
        else      b_q[g*FRAG_W +: FRAG_W] <= wdata[g*FRAG_W +: FRAG_W];
      end
    end
  end

  always_comb begin
    a_frag = a_q[idx*FRAG_W +: FRAG_W];
    b_frag = b_q[idx*FRAG_W +: FRAG_W];
  end

  assign word_o = {b_q, a_q};
endmodule

// File: rtl/frag_slice.sv
module frag_slice
  import swa_pkg::*;
#(
  parameter int unsigned FW = 4
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic [FW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  logic [FW-1:0] b_eff;
  logic [FW:0]   total;

  always_comb begin
    b_eff = sub ? ~b : b;
    total = {1'b0, a} + {1'b0, b_eff} + {{FW{1'b0}}, cin};
    sum   = total[FW-1:0];
    cout  = total[FW];
    ovf   = (a[FW-1] == b_eff[FW-1]) && (total[FW-1] != a[FW-1]);
  end
endmodule

// File: rtl/frag_seq.sv
module frag_seq #(
  parameter int unsigned NFRAG = 8,
  localparam int unsigned IDX_W = (NFRAG > 1) ? $clog2(NFRAG) : 1,
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAG - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_i,
  input  logic             cout_i,
  input  logic             ov_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             op_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             wr_o
);
  logic             busy_q, done_q, op_q, carry_q, ovf_q;
  logic [IDX_W-1:0] idx_q;
  logic             accept;

  assign accept = start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= 1'b0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        op_q    <= op_i;
        carry_q <= op_i;
        ovf_q   <= 1'b0;
      end else if (busy_q) begin
        carry_q <= cout_i;
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          ovf_q  <= ov_i;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign idx_o   = idx_q;
  assign op_o    = op_q;
  assign carry_o = carry_q;
  assign ovf_o   = ovf_q;
  assign wr_o    = busy_q;

  // R4: done is a single-cycle pulse
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R4: busy already low while done is high
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R4: an idle start begins a run at fragment 0 with the select as initial carry
  a_r4_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && idx_q == '0 && carry_q == $past(op_i)));
  // R5: a mid-run start changes neither busy nor the latched select
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != LAST) |=> (busy_q && $stable(op_q)));
  // R9: fragments advance one per cycle, carry taken from the slice
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != LAST) |=> (idx_q == $past(idx_q) + IDX_W'(1) && carry_q == $past(cout_i)));
endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int unsigned OPW    = 32,
  parameter int unsigned FRAG_W = 4,
  localparam int unsigned NFRAG = OPW / FRAG_W,
  localparam int unsigned IDX_W = (NFRAG > 1) ? $clog2(NFRAG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [FRAG_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [FRAG_W-1:0] rd_data,
  output logic [OPW-1:0]    word_o
);
  logic [OPW-1:0] mem_q;

  for (genvar g = 0; g < NFRAG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[g*FRAG_W +: FRAG_W] <= '0;
      else if (we && widx == IDX_W'(g))
        mem_q[g*FRAG_W +: FRAG_W] <= wdata;
    end
  end

  assign rd_data = mem_q[rd_idx*FRAG_W +: FRAG_W];
  assign word_o  = mem_q;
endmodule

// File: rtl/serial_wide_adder.sv
module serial_wide_adder
  import swa_pkg::*;
#(
  parameter int unsigned OPW = 32,
  localparam int unsigned NFRAG = OPW / FRAG_W,
  localparam int unsigned IDX_W = (NFRAG > 1) ? $clog2(NFRAG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_sel,
  input  logic [OPW-1:0]    ld_data,
  input  logic              start,
  input  logic              op_sub,
  output logic              busy,
  output logic              done,
  output logic              carry_flag,
  output logic              ovf_flag,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [FRAG_W-1:0] rd_data
);
  logic [FRAG_W-1:0] a_frag, b_frag;
  logic [IDX_W-1:0]  idx;
  logic              op_q, carry_q, wr;
  logic [2*OPW-1:0]  opnd_word;
  logic [OPW-1:0]    res_word;
  slice_out_t        sl;

  assign ld_ready = !busy;

  opnd_bank #(.OPW(OPW), .FRAG_W(FRAG_W)) u_opnd (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ld_valid && ld_ready),
    .sel    (ld_sel),
    .wdata  (ld_data),
    .idx    (idx),
    .a_frag (a_frag),
    .b_frag (b_frag),
    .word_o (opnd_word)
  );

  frag_slice #(.FW(FRAG_W)) u_slice (
    .a    (a_frag),
    .b    (b_frag),
    .sub  (op_q),
    .cin  (carry_q),
    .sum  (sl.sum),
    .cout (sl.cout),
    .ovf  (sl.ovf)
  );

  frag_seq #(.NFRAG(NFRAG)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .op_i    (op_sub),
    .cout_i  (sl.cout),
    .ov_i    (sl.ovf),
    .busy_o  (busy),
    .done_o  (done),
    .idx_o   (idx),
    .op_o    (op_q),
    .carry_o (carry_q),
    .ovf_o   (ovf_flag),
    .wr_o    (wr)
  );

  assign carry_flag = carry_q;

  result_bank #(.OPW(OPW), .FRAG_W(FRAG_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr),
    .widx    (idx),
    .wdata   (sl.sum),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .word_o  (res_word)
  );

  // R6: operands cannot change under a running computation
  a_r6_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(opnd_word));
  // R8: result store untouched between runs
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(res_word));
  // R8: flags untouched while idle without a start
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(carry_flag) && $stable(ovf_flag)));
endmodule

// File: tb/serial_wide_adder_bench.sv
`timescale 1ns/1ps
module serial_wide_adder_bench;
  localparam int OPW = 8;
  localparam int NF  = OPW / 4;
  localparam int IW  = (NF > 1) ? $clog2(NF) : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, ld_sel = 1'b0, start = 1'b0, op_sub = 1'b0;
  logic [OPW-1:0] ld_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic ld_ready, busy, done, carry_flag, ovf_flag;
  logic [3:0] rd_data;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  serial_wide_adder #(.OPW(OPW)) u_serial_wide_adder (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_data(ld_data), .start(start), .op_sub(op_sub),
    .busy(busy), .done(done), .carry_flag(carry_flag), .ovf_flag(ovf_flag),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_result(output logic [OPW-1:0] w);
    for (int k = 0; k < NF; k++) begin
      rd_idx = IW'(k);
      #0.2;
      w[k*4 +: 4] = rd_data;
    end
  endtask

  // expected values from the arithmetic definition
  function automatic logic [OPW+1:0] model(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input bit sub);
    logic [OPW-1:0] be;
    logic [OPW:0]   t;
    logic           ov;
    be = sub ? ~b : b;
    t  = {1'b0, a} + {1'b0, be} + (OPW+1)'(sub);
    ov = (a[OPW-1] == be[OPW-1]) && (t[OPW-1] != a[OPW-1]);
    return {ov, t};
  endfunction

  task automatic load(input bit sel, input logic [OPW-1:0] d);
    ld_valid = 1'b1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic go(input bit sub);
    start = 1'b1; op_sub = sub;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_and_check(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input bit sub, input string tag);
    logic [OPW+1:0] e;
    logic [OPW-1:0] r;
    e = model(a, b, sub);
    repeat (NF) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R4 done/busy at end", {done, busy}, 2'b10);
    read_result(r);
    chk(r == e[OPW-1:0], tag, r, e[OPW-1:0]);
    chk(carry_flag == e[OPW], sub ? "R2 carry/no-borrow" : "R1 carry", carry_flag, e[OPW]);
    chk(ovf_flag == e[OPW+1], "R3 overflow", ovf_flag, e[OPW+1]);
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog: actual timeout expected completion");
    fails++; checks++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [OPW-1:0] r;
    logic [OPW+1:0] e;
    repeat (3) @(negedge clk);
    // R8: reset state
    read_result(r);
    chk(busy == 0 && done == 0 && carry_flag == 0 && ovf_flag == 0 && r == 0 && ld_ready == 1,
        "R8 reset state", {busy, done, carry_flag, ovf_flag, r}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2/R3 sweep: every A against a spread of B, both operations
    for (int a = 0; a < 256; a++) begin
      for (int j = 0; j < 16; j++) begin
        for (int s = 0; s < 2; s++) begin
          load(1'b0, OPW'(a));
          load(1'b1, OPW'(j * 17));
          go(s[0]);
          finish_and_check(OPW'(a), OPW'(j * 17), s[0], s[0] ? "R2 difference" : "R1 sum");
        end
      end
    end

    // R9: carry and borrow across fragment boundary
    load(1'b0, 8'h0F); load(1'b1, 8'h01); go(1'b0);
    finish_and_check(8'h0F, 8'h01, 1'b0, "R9 carry ripple");
    load(1'b0, 8'h10); load(1'b1, 8'h01); go(1'b1);
    finish_and_check(8'h10, 8'h01, 1'b1, "R9 borrow ripple");

    // R7: fragment 0 readable mid-run
    load(1'b0, 8'h3A); load(1'b1, 8'h25); go(1'b0);
    @(negedge clk);
    rd_idx = '0; #0.2;
    chk(busy == 1'b1 && rd_data == 4'hF, "R7 early fragment", {busy, rd_data}, {1'b1, 4'hF});
    // R5 and R6: mid-run start with other op, and mid-run load
    chk(ld_ready == 1'b0, "R6 ready low while busy", ld_ready, 1'b0);
    start = 1'b1; op_sub = 1'b1; ld_valid = 1'b1; ld_sel = 1'b0; ld_data = 8'hC4;
    @(negedge clk);
    start = 1'b0; ld_valid = 1'b0;
    e = model(8'h3A, 8'h25, 1'b0);
    read_result(r);
    chk(done == 1'b1 && r == e[OPW-1:0], "R5 start ignored while busy", r, e[OPW-1:0]);
    // R8: values hold while idle
    repeat (5) @(negedge clk);
    read_result(r);
    chk(r == e[OPW-1:0] && carry_flag == e[OPW] && ovf_flag == e[OPW+1], "R8 hold after run", r, e[OPW-1:0]);
    // R6: dropped load left A at 0x3A
    go(1'b1);
    finish_and_check(8'h3A, 8'h25, 1'b1, "R6 dropped load left A intact");

    // Same-cycle collision: load A and start in the done cycle
    load(1'b0, 8'h7F); load(1'b1, 8'h01); go(1'b0);
    repeat (NF) @(negedge clk);
    chk(done == 1'b1, "R4 done before chained start", done, 1'b1);
    e = model(8'h7F, 8'h01, 1'b0);
    read_result(r);
    chk(r == e[OPW-1:0] && ovf_flag == 1'b1, "R3 positive overflow", {ovf_flag, r}, {1'b1, e[OPW-1:0]});
    ld_valid = 1'b1; ld_sel = 1'b0; ld_data = 8'h80; start = 1'b1; op_sub = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0; start = 1'b0;
    finish_and_check(8'h80, 8'h01, 1'b1, "R6 load with start in done cycle");
    @(negedge clk);
    chk(done == 1'b0, "R4 done lasts one cycle", done, 1'b0);

    // R8: reset clears a loaded result
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_result(r);
    chk(r == 0 && carry_flag == 0 && ovf_flag == 0, "R8 reset clears", {carry_flag, ovf_flag, r}, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule